// File: doc/BRIEF.md
# Short-Window Sequence Match Engine

This block scans a stream of amino-acid symbols for short seeds. A seed is a window of four consecutive symbols. Up to sixteen four-symbol patterns are programmed into the engine: the window cut from a sample chain, plus any mutated variants of it chosen by software. Each new database symbol shifts a four-symbol window forward by one position. In the same cycle, all enabled patterns are compared against that window.

When a pattern hits, the engine tries to grow the match. Each following database symbol is compared, exactly, with a programmed extension reference: the sample chain continuing past the seed. The extension stops at the first mismatch or at a programmed length limit. The engine then emits one record with three fields: the database offset where the match starts, the index of the winning pattern and the total match length.

The symbol that ends an extension is held back, not consumed, so its own window is still searched for a seed. Configuration writes are accepted only while no extension is running.

Top module: `smx_engine`

## Requirements
- R1: After reset, `m_valid` is 0, `cfg_ready` is 1, `s_ready` is 1, no pattern is enabled and the extension length is 0.
- R2: A write with `cfg_kind`=0 stores pattern `cfg_addr` and enables it. `cfg_data[4:0]` holds the earliest symbol of the window, and `cfg_data[19:15]` holds the latest. The window formed by four consecutive accepted symbols hits an enabled pattern equal to it. The record offset is the stream index of the first of the four symbols, counting accepted symbols from 0 after reset.
- R3: Every stream position is a seed candidate. Windows that overlap are each reported when each hits outside an extension.
- R4: When several enabled patterns hit the same window, `m_pat` gives the lowest index.
- R5: After a hit, each following symbol is compared with extension entry 0, 1, 2 and so on. Entries are written with `cfg_kind`=1 at `cfg_addr` with the symbol in `cfg_data[4:0]`. Each equal symbol is accepted and adds 1 to the length, which starts at 4. The first unequal symbol ends the extension and is not accepted (`s_ready` low). It is then taken in scan mode and searched as a seed position.
- R6: `cfg_kind`=2 sets the extension length from `cfg_data[7:0]`, clamped to 251. An extension stops without a mismatch once the match length reaches 4 plus that value, so it never exceeds 255.
- R7: While an extension is running, `cfg_ready` is 0 and configuration writes of every kind have no effect.
- R8: `cfg_kind`=3 disables pattern `cfg_addr`; other patterns keep matching.
- R9: While `m_valid`=1 and `m_ready`=0, the record holds steady. An extension that ends in that state waits with `s_ready` low, and no record is lost.
- R10: Cycles with `s_valid` low change nothing, so the records do not depend on gaps in the stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 2 | 0 pattern, 1 extension symbol, 2 extension length, 3 pattern disable |
| cfg_addr | input | 8 | Pattern index or extension entry |
| cfg_data | input | 20 | Write data, symbol k in bits [5k+4:5k] |
| cfg_ready | output | 1 | High when writes are taken (not extending) |
| s_valid | input | 1 | Database symbol valid |
| s_ready | output | 1 | Engine accepts the symbol this cycle |
| s_sym | input | 5 | Database symbol code |
| m_valid | output | 1 | Match record valid |
| m_ready | input | 1 | Record consumer ready |
| m_offset | output | 32 | Stream index of the first matching symbol |
| m_pat | output | 4 | Winning pattern index |
| m_len | output | 8 | Total match length, 4 to 255 |

## Verification
Suppose the window register or the position counter slips by one symbol. The very next record would then show it, either as an offset off by one or as a hit that moves to a neighbouring position. Damage to the pattern store or the priority order appears as a missing record or a wrong `m_pat` on the first seed that uses the affected entry. An error in the extension index or the length limit appears only when the record leaves. That is at least one cycle after the last compared symbol, and the wrong value shows in `m_len` or in a missing hold-back on `s_ready`.

// File: rtl/smx_pkg.sv
package smx_pkg;

    localparam int SYM_W     = 5;
    localparam int SEED_LEN  = 4;
    localparam int NPAT      = 16;
    localparam int PAT_IDX_W = $clog2(NPAT);
    localparam int LEN_W     = 8;
    localparam int OFF_W     = 32;
    localparam int MAX_LEN   = (1 << LEN_W) - 1;
    localparam int EXT_DEPTH = MAX_LEN - SEED_LEN;
    localparam int EXT_IDX_W = $clog2(EXT_DEPTH + 1);
    localparam int ADDR_W    = EXT_IDX_W;
    localparam int CFG_W     = SEED_LEN * SYM_W;
    localparam int FILL_W    = $clog2(SEED_LEN);

    typedef logic [SYM_W-1:0] sym_t;
    typedef sym_t [SEED_LEN-1:0] seed_t;

    typedef enum logic [1:0] {
        CFG_PAT  = 2'd0,
        CFG_EXT  = 2'd1,
        CFG_ELEN = 2'd2,
        CFG_DROP = 2'd3
    } cfg_kind_e;

    typedef enum logic {
        ST_SCAN = 1'b0,
        ST_EXT  = 1'b1
    } state_e;

    typedef struct packed {
        logic [OFF_W-1:0]     off;
        logic [PAT_IDX_W-1:0] pat;
        logic [LEN_W-1:0]     len;
    } rec_t;

    // newest symbol enters at the top index, oldest leaves from index 0
    function automatic seed_t push_sym(seed_t w, sym_t s);
        return {s, w[SEED_LEN-1:1]};
    endfunction

    function automatic logic [LEN_W-1:0] clamp_ext(logic [LEN_W-1:0] v);
        return (int'(v) > EXT_DEPTH) ? LEN_W'(EXT_DEPTH) : v;
    endfunction

endpackage

// File: rtl/smx_cfg_store.sv
module smx_cfg_store
    import smx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  cfg_kind_e         kind,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CFG_W-1:0]  data,
    input  logic [EXT_IDX_W-1:0] rd_idx,
    output seed_t             pats [NPAT],
    output logic [NPAT-1:0]   pat_en,
    output sym_t              rd_sym,
    output logic [LEN_W-1:0]  ext_len
);

    sym_t ext_mem [EXT_DEPTH];

    for (genvar p = 0; p < NPAT; p++) begin : g_pat
        logic hit_addr;
        assign hit_addr = (int'(addr) == p);
        always_ff @(posedge clk) begin
            if (rst) begin
                pats[p]   <= '0;
                pat_en[p] <= 1'b0;
            end else if (wr && hit_addr) begin
                if (kind == CFG_PAT) begin
                    pats[p]   <= seed_t'(data);
                    pat_en[p] <= 1'b1;
                end else if (kind == CFG_DROP) begin
                    pat_en[p] <= 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (wr && kind == CFG_EXT && int'(addr) < EXT_DEPTH) begin
            ext_mem[addr] <= data[SYM_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ext_len <= '0;
        end else if (wr && kind == CFG_ELEN) begin
            ext_len <= clamp_ext(data[LEN_W-1:0]);
        end
    end

    assign rd_sym = (int'(rd_idx) < EXT_DEPTH) ? ext_mem[rd_idx] : '0;

endmodule

// File: rtl/smx_window.sv
module smx_window
    import smx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    input  sym_t             sym,
    output seed_t            cand,
    output logic             cand_ok,
    output logic [OFF_W-1:0] pos
);

    seed_t             win;
    logic [FILL_W-1:0] fill;

    assign cand    = push_sym(win, sym);
    assign cand_ok = (int'(fill) == SEED_LEN - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            win  <= '0;
            fill <= '0;
            pos  <= '0;
        end else if (adv) begin
            win <= cand;
            pos <= pos + 1'b1;
            if (!cand_ok) begin
                fill <= fill + 1'b1;
            end
        end
    end

endmodule

// File: rtl/smx_seed_match.sv
module smx_seed_match
    import smx_pkg::*;
(
    input  seed_t                cand,
    input  logic                 cand_ok,
    input  seed_t                pats [NPAT],
    input  logic [NPAT-1:0]      pat_en,
    output logic                 hit,
    output logic [PAT_IDX_W-1:0] hit_idx
);

    logic [NPAT-1:0] eq_vec;

    for (genvar p = 0; p < NPAT; p++) begin : g_cmp
        assign eq_vec[p] = cand_ok && pat_en[p] && (pats[p] == cand);
    end

    // scan from the top so the lowest matching index is written last
    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = NPAT - 1; i >= 0; i--) begin
            if (eq_vec[i]) begin
                hit     = 1'b1;
                hit_idx = PAT_IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/smx_engine.sv
module smx_engine
    import smx_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic [1:0]  cfg_kind,
    input  logic [7:0]  cfg_addr,
    input  logic [19:0] cfg_data,
    output logic        cfg_ready,
    input  logic        s_valid,
    output logic        s_ready,
    input  logic [4:0]  s_sym,
    output logic        m_valid,
    input  logic        m_ready,
    output logic [31:0] m_offset,
    output logic [3:0]  m_pat,
    output logic [7:0]  m_len
);

    state_e                state;
    rec_t                  cur;
    rec_t                  out_rec;
    logic                  out_v;
    logic [EXT_IDX_W-1:0]  ext_idx;

    seed_t                 pats [NPAT];
    logic [NPAT-1:0]       pat_en;
    sym_t                  ext_sym;
    logic [LEN_W-1:0]      ext_len;

    seed_t                 cand;
    logic                  cand_ok;
    logic [OFF_W-1:0]      pos;
    logic                  hit;
    logic [PAT_IDX_W-1:0]  hit_idx;

    logic                  cfg_take;
    logic                  slot_free;
    logic [LEN_W:0]        cap_len;
    logic                  at_cap;
    logic                  ext_ok;
    logic                  ext_stop;
    logic                  accept;

    assign cfg_ready = (state == ST_SCAN);
    assign cfg_take  = cfg_we && cfg_ready;

    smx_cfg_store u_store (
        .clk     (clk),
        .rst     (rst),
        .wr      (cfg_take),
        .kind    (cfg_kind_e'(cfg_kind)),
        .addr    (cfg_addr),
        .data    (cfg_data),
        .rd_idx  (ext_idx),
        .pats    (pats),
        .pat_en  (pat_en),
        .rd_sym  (ext_sym),
        .ext_len (ext_len)
    );

    smx_window u_win (
        .clk     (clk),
        .rst     (rst),
        .adv     (accept),
        .sym     (s_sym),
        .cand    (cand),
        .cand_ok (cand_ok),
        .pos     (pos)
    );

    smx_seed_match u_match (
        .cand    (cand),
        .cand_ok (cand_ok),
        .pats    (pats),
        .pat_en  (pat_en),
        .hit     (hit),
        .hit_idx (hit_idx)
    );

    always_comb begin
        slot_free = !out_v || m_ready;
        cap_len   = (LEN_W+1)'(SEED_LEN) + {1'b0, ext_len};
        at_cap    = ({1'b0, cur.len} == cap_len);
        ext_ok    = s_valid && (s_sym == ext_sym) && !at_cap;
        ext_stop  = at_cap || (s_valid && (s_sym != ext_sym));
        s_ready   = (state == ST_SCAN) ? 1'b1 : ext_ok;
        accept    = s_valid && s_ready;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_SCAN;
            cur     <= '0;
            out_rec <= '0;
            out_v   <= 1'b0;
            ext_idx <= '0;
        end else begin
            if (out_v && m_ready) begin
                out_v <= 1'b0;
            end
            case (state)
                ST_SCAN: begin
                    if (accept && hit) begin
                        state   <= ST_EXT;
                        cur.off <= pos - OFF_W'(SEED_LEN - 1);
                        cur.pat <= hit_idx;
                        cur.len <= LEN_W'(SEED_LEN);
                        ext_idx <= '0;
                    end
                end
                ST_EXT: begin
                    if (ext_ok) begin
                        cur.len <= cur.len + 1'b1;
                        ext_idx <= ext_idx + 1'b1;
                    end else if (ext_stop && slot_free) begin
                        out_rec <= cur;
                        out_v   <= 1'b1;
                        state   <= ST_SCAN;
                    end
                end
                default: state <= ST_SCAN;
            endcase
        end
    end

    assign m_valid  = out_v;
    assign m_offset = out_rec.off;
    assign m_pat    = out_rec.pat;
    assign m_len    = out_rec.len;

endmodule

// File: rtl/smx_engine_chk.sv
module smx_engine_chk
    import smx_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        cfg_ready,
    input logic        s_valid,
    input logic        s_ready,
    input logic        m_valid,
    input logic        m_ready,
    input logic [31:0] m_offset,
    input logic [3:0]  m_pat,
    input logic [7:0]  m_len
);

    logic [31:0] last_off;
    logic        have_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_off  <= '0;
            have_last <= 1'b0;
        end else if (m_valid && m_ready) begin
            last_off  <= m_offset;
            have_last <= 1'b1;
        end
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (!m_valid && cfg_ready));

    // R9
    record_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (m_valid && !m_ready) |=> (m_valid && $stable({m_offset, m_pat, m_len})));

    // R6
    min_len_chk: assert property (@(posedge clk) disable iff (rst)
        m_valid |-> (int'(m_len) >= SEED_LEN));

    // R5
    record_from_ext_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(m_valid) |-> $past(!cfg_ready));

    // R3
    offset_order_chk: assert property (@(posedge clk) disable iff (rst)
        (m_valid && m_ready && have_last) |-> (m_offset > last_off));

    // R5
    scan_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (s_valid && !s_ready) |-> !cfg_ready);

endmodule

bind smx_engine smx_engine_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_ready (cfg_ready),
    .s_valid   (s_valid),
    .s_ready   (s_ready),
    .m_valid   (m_valid),
    .m_ready   (m_ready),
    .m_offset  (m_offset),
    .m_pat     (m_pat),
    .m_len     (m_len)
);

// File: tb/smx_engine_tb.sv
`timescale 1ns/1ps
module smx_engine_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_kind = '0;
    logic [7:0]  cfg_addr = '0;
    logic [19:0] cfg_data = '0;
    logic        cfg_ready;
    logic        s_valid = 1'b0;
    logic        s_ready;
    logic [4:0]  s_sym = '0;
    logic        m_valid;
    logic        m_ready = 1'b1;
    logic [31:0] m_offset;
    logic [3:0]  m_pat;
    logic [7:0]  m_len;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    int          nrec;
    logic [31:0] r_off [16];
    logic [3:0]  r_pat [16];
    logic [7:0]  r_len [16];

    always #4 clk = ~clk;

    smx_engine u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
        .cfg_addr(cfg_addr), .cfg_data(cfg_data), .cfg_ready(cfg_ready),
        .s_valid(s_valid), .s_ready(s_ready), .s_sym(s_sym),
        .m_valid(m_valid), .m_ready(m_ready), .m_offset(m_offset),
        .m_pat(m_pat), .m_len(m_len)
    );

    // record monitor, sampled mid-cycle
    always @(negedge clk) begin
        #2;
        if (rst) begin
            nrec = 0;
        end else if (m_valid && m_ready) begin
            if (nrec < 16) begin
                r_off[nrec] = m_offset;
                r_pat[nrec] = m_pat;
                r_len[nrec] = m_len;
            end
            nrec++;
        end
    end

    localparam int NCASE = 5;
    localparam int MAXS  = 9;
    localparam int T_SYM [NCASE][MAXS] = '{
        '{9, 1, 2, 3, 4, 5, 6, 8, -1},
        '{7, 2, 3, 4, 5, 6, 7, 5, -1},
        '{0, 0, 8, 8, 8, 8, 9, -1, -1},
        '{1, 2, 3, 9, 1, 2, 3, 4, 0},
        '{12, 13, 14, 15, 16, 17, -1, -1, -1}
    };
    localparam int T_NREC [NCASE] = '{1, 1, 1, 1, 0};
    localparam int T_OFF  [NCASE] = '{1, 0, 2, 4, 0};
    localparam int T_PAT  [NCASE] = '{0, 1, 2, 0, 0};
    localparam int T_LEN  [NCASE] = '{6, 7, 4, 4, 0};

    task automatic check(input string tag, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; s_valid = 1'b0; cfg_we = 1'b0; m_ready = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic cfg_write(input int kind, input int addr, input logic [19:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_kind = 2'(kind); cfg_addr = 8'(addr); cfg_data = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic load_pat(input int idx, input int a, input int b, input int c, input int d);
        cfg_write(0, idx, {5'(d), 5'(c), 5'(b), 5'(a)});
    endtask

    task automatic send(input int sym, input int gap);
        repeat (gap) @(negedge clk);
        @(negedge clk);
        s_valid = 1'b1; s_sym = 5'(sym);
        #1;
        while (!s_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1;
        s_valid = 1'b0;
    endtask

    task automatic drain();
        repeat (4) @(negedge clk);
        #3;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        do_reset();
        #2;
        check("R1 m_valid", m_valid, 0);
        check("R1 cfg_ready", cfg_ready, 1);
        check("R1 s_ready", s_ready, 1);

        // table walk; second pass inserts idle gaps (R10)
        for (int pass = 0; pass < 2; pass++) begin
            for (int c = 0; c < NCASE; c++) begin
                do_reset();
                load_pat(0, 1, 2, 3, 4);
                load_pat(1, 7, 2, 3, 4);
                load_pat(2, 8, 8, 8, 8);
                load_pat(5, 8, 8, 8, 8);
                cfg_write(1, 0, 20'd5);
                cfg_write(1, 1, 20'd6);
                cfg_write(1, 2, 20'd7);
                cfg_write(2, 0, 20'd3);
                for (int k = 0; k < MAXS; k++) begin
                    if (T_SYM[c][k] >= 0) send(T_SYM[c][k], pass * 2);
                end
                drain();
                check($sformatf("%s case %0d count", pass ? "R10" : "R2", c), nrec, T_NREC[c]);
                if (T_NREC[c] > 0 && nrec > 0) begin
                    check($sformatf("R2 case %0d offset", c), r_off[0], T_OFF[c]);
                    check($sformatf("R4 case %0d pattern", c), r_pat[0], T_PAT[c]);
                    check($sformatf("%s case %0d length", (c == 1) ? "R6" : "R5", c),
                          r_len[0], T_LEN[c]);
                end
            end
        end

        // R3 overlapping seeds
        do_reset();
        load_pat(0, 1, 1, 1, 1);
        for (int k = 0; k < 6; k++) send(1, 0);
        drain();
        check("R3 overlap count", nrec, 3);
        for (int k = 0; k < 3; k++) begin
            if (nrec > k) begin
                check("R3 overlap offset", r_off[k], k);
                check("R3 overlap length", r_len[k], 4);
            end
        end

        // R7 writes ignored while extending
        do_reset();
        load_pat(0, 1, 2, 3, 4);
        cfg_write(1, 0, 20'd5);
        cfg_write(1, 1, 20'd6);
        cfg_write(1, 2, 20'd7);
        cfg_write(2, 0, 20'd3);
        send(1, 0); send(2, 0); send(3, 0); send(4, 0);
        @(negedge clk);
        #1;
        check("R7 cfg_ready low in extension", cfg_ready, 0);
        load_pat(1, 9, 9, 9, 9);
        cfg_write(2, 0, 20'd0);
        send(5, 0); send(6, 0); send(7, 0);
        send(9, 0); send(9, 0); send(9, 0); send(9, 0); send(0, 0);
        drain();
        check("R7 record count", nrec, 1);
        if (nrec > 0) check("R7 length keeps old limit", r_len[0], 7);

        // R8 disable one pattern
        do_reset();
        load_pat(0, 1, 2, 3, 4);
        load_pat(1, 1, 2, 3, 4);
        cfg_write(3, 0, 20'd0);
        send(1, 0); send(2, 0); send(3, 0); send(4, 0); send(0, 0);
        drain();
        check("R8 record count", nrec, 1);
        if (nrec > 0) check("R8 surviving pattern", r_pat[0], 1);

        // R9 output stall
        do_reset();
        load_pat(0, 1, 1, 1, 1);
        @(negedge clk);
        m_ready = 1'b0;
        for (int k = 0; k < 5; k++) send(1, 0);
        repeat (3) @(negedge clk);
        #3;
        check("R9 held valid", m_valid, 1);
        check("R9 held offset", m_offset, 0);
        check("R9 second extension waits", cfg_ready, 0);
        @(negedge clk);
        m_ready = 1'b1;
        drain();
        check("R9 record count", nrec, 2);
        if (nrec > 1) begin
            check("R9 first offset", r_off[0], 0);
            check("R9 second offset", r_off[1], 1);
        end

        // R6 clamp to 255
        do_reset();
        load_pat(0, 1, 1, 1, 1);
        for (int k = 0; k < 251; k++) cfg_write(1, k, 20'd1);
        cfg_write(2, 0, 20'd255);
        for (int k = 0; k < 255; k++) send(1, 0);
        send(0, 0);
        drain();
        check("R6 cap count", nrec, 1);
        if (nrec > 0) begin
            check("R6 cap length", r_len[0], 255);
            check("R6 cap offset", r_off[0], 0);
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule